// File: doc/BRIEF.md
# Sixteen-Line Interrupt Expander

The block gathers sixteen external interrupt request lines into one level-sensitive, active-high interrupt line for a host processor. Every cycle in which a request line is high sets its bit in a pending-status register. Each pending bit is gated by an enable bit, and the host line is asserted while any pending bit is also enabled. The host reaches the block through a small synchronous 16-bit register bus. It has an address, a write strobe with write data, and a read strobe with registered read data.

Software never needs a read-modify-write. Enable bits are turned on by writing ones to a set address and turned off by writing ones to a separate clear address. Pending bits are cleared by writing ones to the status address. A fourth address returns the live, unlatched level of the sixteen request lines, so a handler can tell whether a source still requests service.

On the board these lines are spoken for as follows: line 8 serves an Ethernet controller, and lines 10 and 11 serve the two channels of a dual serial port.

Top module: `irq_expander`

## Requirements
- R1: Reset is active-low and asynchronous. While it is low, pending status, enable mask, `irq_o` and `rd_data_o` are all zero.
- R2: A pending bit becomes 1 at any clock edge where its request line is high. It stays 1 after the line falls, until software clears it.
- R3: A write to offset 0x16 clears each pending bit whose data bit is 1 and leaves the bits written with 0 unchanged. At that edge the clear wins over a high request line. If the line is still high, the bit sets again at the following edge. Writing 0xFFFF clears all pending bits.
- R4: A read of offset 0x18 returns the level of the sixteen request lines at the edge where the read is sampled. Writes to 0x18 change neither status nor mask.
- R5: A write to offset 0x1A sets each enable bit whose data bit is 1 and leaves the other bits unchanged. A read of 0x1A returns the enable mask.
- R6: A write to offset 0x1C clears each enable bit whose data bit is 1 and leaves the other bits unchanged. Writing 0xFFFF disables every source.
- R7: `irq_o` is registered. After each edge it equals the OR over all bits of (pending AND enable) as those registers held before that edge, giving one cycle of latency.
- R8: Reads of offset 0x1C and of any unmapped offset return 0. Writes to unmapped offsets change neither status nor mask.
- R9: `rd_data_o` loads at the edge where `rd_i` is sampled high, with the register value from before that edge. It holds its value while `rd_i` is low. A read of 0x16 returns the pending status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Interrupt request lines, active high, bit n is source n |
| addr_i | input | 8 | Register offset |
| wr_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the host, active high |

## Verification
The hardest case to reach is a write-one-to-clear that lands in the same cycle as a still-high request line. The clear must win at that edge, and the bit must set again at the next edge. Directed stimulus holds a request line high, issues the clear, and reads status on the two following cycles, expecting zero and then the bit. Random traffic with sparse request patterns and random writes to all four offsets then mixes clears, mask changes and reads. A bench model checks every cycle's interrupt and read data against these rules.

// File: rtl/irqx_pkg.sv
package irqx_pkg;

    // Selects which value a read loads into the read-data register.
    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_STAT = 2'd1,
        RSEL_LIVE = 2'd2,
        RSEL_MASK = 2'd3
    } rsel_e;

    // Strobes that come out of the address decoder.
    typedef struct packed {
        logic  wr_stat;
        logic  wr_set;
        logic  wr_clr;
        logic  rd_go;
        rsel_e rsel;
    } dec_t;

endpackage

// File: rtl/irqx_decode.sv
module irqx_decode
    import irqx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] STAT_OFF = ADDR_W'('h16),
    parameter logic [ADDR_W-1:0] LIVE_OFF = ADDR_W'('h18),
    parameter logic [ADDR_W-1:0] SET_OFF  = ADDR_W'('h1A),
    parameter logic [ADDR_W-1:0] CLR_OFF  = ADDR_W'('h1C)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output dec_t              dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.rd_go   = rd_i;
        dec_o.wr_stat = wr_i && (addr_i == STAT_OFF);
        dec_o.wr_set  = wr_i && (addr_i == SET_OFF);
        dec_o.wr_clr  = wr_i && (addr_i == CLR_OFF);
        if (addr_i == STAT_OFF) begin
            dec_o.rsel = RSEL_STAT;
        end else if (addr_i == LIVE_OFF) begin
            dec_o.rsel = RSEL_LIVE;
        end else if (addr_i == SET_OFF) begin
            dec_o.rsel = RSEL_MASK;
        end else begin
            dec_o.rsel = RSEL_ZERO;
        end
    end

endmodule

// File: rtl/irqx_rdmux.sv
module irqx_rdmux
    import irqx_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  rsel_e              rsel_i,
    input  logic [N_SRC-1:0]   stat_i,
    input  logic [N_SRC-1:0]   live_i,
    input  logic [N_SRC-1:0]   mask_i,
    output logic [N_SRC-1:0]   val_o
);

    always_comb begin
        unique case (rsel_i)
            RSEL_STAT: val_o = stat_i;
            RSEL_LIVE: val_o = live_i;
            RSEL_MASK: val_o = mask_i;
            default:   val_o = '0;
        endcase
    end

endmodule

// File: rtl/irqx_state.sv
module irqx_state
    import irqx_pkg::*;
#(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_i,
    input  logic [N_SRC-1:0] wr_data_i,
    input  dec_t             dec_i,
    input  logic [N_SRC-1:0] rd_val_i,
    output logic [N_SRC-1:0] stat_o,
    output logic [N_SRC-1:0] mask_o,
    output logic [N_SRC-1:0] rd_data_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_SRC-1:0] stat;
        logic [N_SRC-1:0] mask;
        logic [N_SRC-1:0] rd;
        logic             irq;
    } st_t;

    st_t st_d, st_q;
    logic [N_SRC-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = dec_i.wr_stat ? wr_data_i : '0;
        // clearing wins over a request seen at the same edge
        st_d.stat = (st_q.stat | req_i) & ~clr_d;
        if (dec_i.wr_set) begin
            st_d.mask = st_q.mask | wr_data_i;
        end
        if (dec_i.wr_clr) begin
            st_d.mask = st_q.mask & ~wr_data_i;
        end
        st_d.irq = |(st_q.stat & st_q.mask);
        if (dec_i.rd_go) begin
            st_d.rd = rd_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_o    = st_q.stat;
    assign mask_o    = st_q.mask;
    assign rd_data_o = st_q.rd;
    assign irq_o     = st_q.irq;

endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [N_SRC-1:0]  wr_data_i,
    input  logic              rd_i,
    output logic [N_SRC-1:0]  rd_data_o,
    output logic              irq_o
);

    dec_t             dec_w;
    logic [N_SRC-1:0] stat_q;
    logic [N_SRC-1:0] mask_q;
    logic [N_SRC-1:0] rd_val_w;

    irqx_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .wr_i   (wr_i),
        .rd_i   (rd_i),
        .dec_o  (dec_w)
    );

    irqx_rdmux #(.N_SRC(N_SRC)) u_rdmux (
        .rsel_i (dec_w.rsel),
        .stat_i (stat_q),
        .live_i (req_i),
        .mask_i (mask_q),
        .val_o  (rd_val_w)
    );

    irqx_state #(.N_SRC(N_SRC)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .wr_data_i (wr_data_i),
        .dec_i     (dec_w),
        .rd_val_i  (rd_val_w),
        .stat_o    (stat_q),
        .mask_o    (mask_q),
        .rd_data_o (rd_data_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/irq_expander_chk.sv
module irq_expander_chk #(
    parameter int N_SRC  = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  req_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic [N_SRC-1:0]  wr_data_i,
    input logic              rd_i,
    input logic [N_SRC-1:0]  rd_data_o,
    input logic              irq_o,
    input logic [N_SRC-1:0]  stat_q,
    input logic [N_SRC-1:0]  mask_q
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h16);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'('h1A);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'('h1C);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0 && mask_q == '0 && irq_o == 1'b0));

    // R2
    req_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == A_STAT) |=> ((stat_q & $past(req_i)) == $past(req_i)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_STAT) |=> ((stat_q & $past(wr_data_i)) == '0));

    // R5
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_SET) |=> ((mask_q & $past(wr_data_i)) == $past(wr_data_i)));

    // R6
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == A_CLR) |=> ((mask_q & $past(wr_data_i)) == '0));

    // R8
    mask_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && (addr_i == A_SET || addr_i == A_CLR)) |=> $stable(mask_q));

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & mask_q)) |=> irq_o);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & mask_q)) |=> !irq_o);

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rd_data_o));

endmodule

bind irq_expander irq_expander_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .rd_i      (rd_i),
    .rd_data_o (rd_data_o),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/irq_expander_test.sv
`timescale 1ns/1ps
module irq_expander_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wd = '0;
    logic        rd = 1'b0;
    logic [15:0] rd_data;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] m_stat, m_mask, m_rd;
    logic        m_irq;

    always #2 clk = ~clk;

    irq_expander uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .addr_i    (addr),
        .wr_i      (wr),
        .wr_data_i (wd),
        .rd_i      (rd),
        .rd_data_o (rd_data),
        .irq_o     (irq)
    );

    function automatic logic [15:0] rd_value(input logic [7:0] a, input logic [15:0] st,
                                             input logic [15:0] lv, input logic [15:0] mk);
        case (a)
            8'h16:   return st;
            8'h18:   return lv;
            8'h1A:   return mk;
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat <= '0;
            m_mask <= '0;
            m_rd   <= '0;
            m_irq  <= 1'b0;
        end else begin
            m_stat <= (m_stat | req) & ~((wr && addr == 8'h16) ? wd : 16'h0);
            if (wr && addr == 8'h1A) m_mask <= m_mask | wd;
            if (wr && addr == 8'h1C) m_mask <= m_mask & ~wd;
            m_irq <= |(m_stat & m_mask);
            if (rd) m_rd <= rd_value(addr, m_stat, req, m_mask);
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string rd_tag(input logic [7:0] a);
        case (a)
            8'h16:   return "R9 status read";
            8'h18:   return "R4 live read";
            8'h1A:   return "R5 mask read";
            default: return "R8 zero read";
        endcase
    endfunction

    // one bus cycle; called at a falling edge, returns at the next one
    task automatic step(input logic [7:0] a, input logic w, input logic [15:0] d, input logic r);
        addr = a; wr = w; wd = d; rd = r;
        @(negedge clk);
        addr = '0; wr = 1'b0; wd = '0; rd = 1'b0;
        chk("R7 irq vs model", {15'h0, irq}, {15'h0, m_irq});
        chk(r ? rd_tag(a) : "R9 read hold", rd_data, m_rd);
    endtask

    task automatic rdchk(input string tag, input logic [7:0] a, input logic [15:0] exp);
        step(a, 1'b0, 16'h0, 1'b1);
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 irq in reset", {15'h0, irq}, 16'h0);
        chk("R1 rd_data in reset", rd_data, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rdchk("R1 status after reset", 8'h16, 16'h0);
        rdchk("R1 mask after reset", 8'h1A, 16'h0);

        // R2: one-cycle pulse on line 8 is latched
        req = 16'h0100;
        step(8'h00, 1'b0, 16'h0, 1'b0);
        req = 16'h0000;
        step(8'h00, 1'b0, 16'h0, 1'b0);
        rdchk("R2 pulse latched", 8'h16, 16'h0100);
        chk("R7 masked source gives no irq", {15'h0, irq}, 16'h0);

        // R7: enable line 8, irq follows one cycle later
        step(8'h1A, 1'b1, 16'h0100, 1'b0);
        chk("R7 irq not yet after enable", {15'h0, irq}, 16'h0);
        step(8'h00, 1'b0, 16'h0, 1'b0);
        chk("R7 irq one cycle after enable", {15'h0, irq}, 16'h1);

        // R4: write to live offset ignored
        step(8'h18, 1'b1, 16'hFFFF, 1'b0);
        rdchk("R4 mask unchanged by live write", 8'h1A, 16'h0100);
        rdchk("R4 status unchanged by live write", 8'h16, 16'h0100);

        // R3: zero bits leave status, one bits clear it
        step(8'h16, 1'b1, 16'hFEFF, 1'b0);
        rdchk("R3 zero bit leaves pending", 8'h16, 16'h0100);
        step(8'h16, 1'b1, 16'h0100, 1'b0);
        rdchk("R3 one bit clears pending", 8'h16, 16'h0000);
        chk("R7 irq drops after clear", {15'h0, irq}, 16'h0);

        // R3: clear with line still high wins, then re-sets
        req = 16'h0400;
        step(8'h00, 1'b0, 16'h0, 1'b0);
        step(8'h16, 1'b1, 16'h0400, 1'b0);
        rdchk("R3 clear wins at its edge", 8'h16, 16'h0000);
        rdchk("R3 bit re-sets next cycle", 8'h16, 16'h0400);

        // R4: live level
        req = 16'h0C00;
        rdchk("R4 live level", 8'h18, 16'h0C00);
        req = 16'h0000;
        rdchk("R4 live level follows drop", 8'h18, 16'h0000);
        step(8'h16, 1'b1, 16'hFFFF, 1'b0);
        rdchk("R3 all-ones clears all", 8'h16, 16'h0000);

        // R5, R6
        step(8'h1A, 1'b1, 16'hFFFF, 1'b0);
        rdchk("R5 set all", 8'h1A, 16'hFFFF);
        step(8'h1C, 1'b1, 16'h00F0, 1'b0);
        rdchk("R6 partial clear", 8'h1A, 16'hFF0F);
        step(8'h1C, 1'b1, 16'hFFFF, 1'b0);
        rdchk("R6 all-ones disables all", 8'h1A, 16'h0000);

        // R8
        step(8'h1A, 1'b1, 16'h0801, 1'b0);
        rdchk("R8 read of clear offset", 8'h1C, 16'h0000);
        rdchk("R8 read of unmapped offset", 8'h20, 16'h0000);
        step(8'h1E, 1'b1, 16'hFFFF, 1'b0);
        rdchk("R8 unmapped write keeps mask", 8'h1A, 16'h0801);

        // R9: hold while rd low
        held = rd_data;
        step(8'h16, 1'b0, 16'h0, 1'b0);
        chk("R9 read data holds", rd_data, held);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            logic [7:0]  a;
            r = $urandom;
            req = 16'($urandom & $urandom & $urandom);
            case (r[2:0])
                3'd0, 3'd5: a = 8'h16;
                3'd1:       a = 8'h18;
                3'd2:       a = 8'h1A;
                3'd3:       a = 8'h1C;
                default:    a = 8'(r[15:8]);
            endcase
            step(a, r[4:3] == 2'b00, 16'($urandom), r[5]);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule